// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block builds the byte a parallel NOR flash returns when the host reads it while an embedded program, embedded erase or buffered write is running, or while one of those is suspended. A command decoder and the timing engines outside the block tell it the current operation mode, whether the read address falls in the sector being worked on, bit 7 of the data being written, a time-limit-exceeded flag and a buffer-abort flag. Each host read pulses a read strobe. The block returns either a status byte or the array data, and drives an active-low ready/busy line.

Two toggle bits inside the block change from one read to the next. The fast toggle (bit 6) advances on every read while an algorithm runs. The sector toggle (bit 2) advances only on reads of the affected sector during an erase or an erase suspend. A host can therefore tell a running algorithm from a suspended one, and an erasing sector from any other. Both toggles clear when a new operation starts and on reset.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle bits read 0. A reset applied in the middle of a run clears them again.
- R2: Mode codes on `op_mode_i` are 0 idle, 1 program, 2 buffered write, 3 erase, 4 erase suspended, 5 program suspended, 6 program inside erase suspend, 7 reserved (treated as idle). In modes 1 and 6 the status byte is {~wr_bit7, fast toggle, timeout, 5'b0}.
- R3: In mode 3 the status byte is {0, fast toggle, timeout, 0, 1, sector toggle, 0, 0}. This holds whatever the address.
- R4: In mode 4, reads of the suspended sector return {1, fast toggle, 0, 0, 0, sector toggle, 0, 0}. The fast toggle holds its value there, and the timeout and abort inputs have no effect.
- R5: In modes 0 and 7, and for reads outside the affected sector in modes 4 and 5, `status_o` equals `array_data_i`.
- R6: In mode 5, reads inside the suspended sector return 0x00.
- R7: Bit 5 equals `timeout_i` in modes 1, 2, 3 and 6, and reads 0 in every other status mode.
- R8: In mode 2 the status byte is {~wr_bit7, fast toggle, timeout, 0, 0, 0, abort, 0}. Bit 1 reads 1 only in mode 2 with `buf_abort_i` set.
- R9: The fast toggle inverts once for each rising edge of `rd_strobe_i` seen in modes 1, 2, 3 or 6, in the clock after the edge. A strobe held high counts once. Reads in any other mode leave it unchanged.
- R10: The sector toggle inverts once for each rising strobe edge in mode 3 or 4, and only when `in_sector_i` is 1. Otherwise it holds.
- R11: A pulse on `op_start_i` clears both toggles on the next clock. A clear takes priority over a strobe edge in the same cycle.
- R12: `ryby_pull_low_o` is 1 (line pulled low, busy) in modes 1, 2, 3 and 6, and 0 (line released, ready) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode_i | input | 3 | Current operation mode code |
| op_start_i | input | 1 | Pulse marking the start of a new operation |
| in_sector_i | input | 1 | Read address lies in the sector being operated on or suspended |
| wr_bit7_i | input | 1 | Bit 7 of the data being written |
| timeout_i | input | 1 | Operation has exceeded its time limit |
| buf_abort_i | input | 1 | Buffered write was aborted |
| rd_strobe_i | input | 1 | High during a host read; its rising edge counts as one read |
| array_data_i | input | DATA_W | Array data for pass-through reads |
| status_o | output | DATA_W | Status byte or array data |
| ryby_pull_low_o | output | 1 | Open-drain enable: 1 pulls ready/busy low |

## Verification
Assertions check on every cycle that each toggle inverts on a qualified strobe edge and holds otherwise. They also check that a start pulse clears both toggles, that the sector toggle ignores reads outside the sector, and that the fast toggle freezes during an erase suspend. Further cycle-by-cycle checks cover the fixed erase bits, a zero bit 5 without a timeout, and pass-through when idle. Only the bench scenarios show the complete byte for each mode and address combination and the bit sequence over successive reads. They also show that a long strobe counts once, that a mid-run reset clears the toggles, and how toggle state carries across mode changes.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_BUFWR  = 3'd2,
        OP_ERASE  = 3'd3,
        OP_ESUSP  = 3'd4,
        OP_PSUSP  = 3'd5,
        OP_ESPROG = 3'd6,
        OP_RSVD   = 3'd7
    } op_mode_e;

    // status bit positions decoded by host polling software
    localparam int B_POLL   = 7;
    localparam int B_FAST   = 6;
    localparam int B_TMO    = 5;
    localparam int B_ERS    = 3;
    localparam int B_SECT   = 2;
    localparam int B_ABORT  = 1;

    typedef struct packed {
        logic strobe;
    } edge_state_t;

    function automatic logic mode_busy(op_mode_e m);
        return (m == OP_PROG) || (m == OP_BUFWR) || (m == OP_ERASE) || (m == OP_ESPROG);
    endfunction

endpackage

// File: rtl/stat_toggle_cell.sv
module stat_toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic q_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (clr_i)
            bit_d = 1'b0;
        else if (adv_i)
            bit_d = ~bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else
            bit_q <= bit_d;
    end

    assign q_o = bit_q;

    // R11: clear wins
    a_r11_cell_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == 1'b0));

endmodule

// File: rtl/stat_word_mux.sv
module stat_word_mux
    import flash_stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_mode_e          mode_i,
    input  logic              in_sector_i,
    input  logic              wr_bit7_i,
    input  logic              timeout_i,
    input  logic              buf_abort_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic              fast_tgl_i,
    input  logic              sect_tgl_i,
    output logic [DATA_W-1:0] status_o,
    output logic              pull_low_o
);
    logic [DATA_W-1:0] word_d;

    always_comb begin
        word_d = '0;
        unique case (mode_i)
            OP_PROG, OP_ESPROG: begin
                word_d[B_POLL] = ~wr_bit7_i;
                word_d[B_FAST] = fast_tgl_i;
                word_d[B_TMO]  = timeout_i;
            end
            OP_BUFWR: begin
                word_d[B_POLL]  = ~wr_bit7_i;
                word_d[B_FAST]  = fast_tgl_i;
                word_d[B_TMO]   = timeout_i;
                word_d[B_ABORT] = buf_abort_i;
            end
            OP_ERASE: begin
                word_d[B_FAST] = fast_tgl_i;
                word_d[B_TMO]  = timeout_i;
                word_d[B_ERS]  = 1'b1;
                word_d[B_SECT] = sect_tgl_i;
            end
            OP_ESUSP: begin
                if (in_sector_i) begin
                    word_d[B_POLL] = 1'b1;
                    word_d[B_FAST] = fast_tgl_i;
                    word_d[B_SECT] = sect_tgl_i;
                end else begin
                    word_d = array_data_i;
                end
            end
            OP_PSUSP: begin
                if (!in_sector_i)
                    word_d = array_data_i;
            end
            default: word_d = array_data_i;
        endcase
    end

    assign status_o   = word_d;
    assign pull_low_o = mode_busy(mode_i);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode_i,
    input  logic              op_start_i,
    input  logic              in_sector_i,
    input  logic              wr_bit7_i,
    input  logic              timeout_i,
    input  logic              buf_abort_i,
    input  logic              rd_strobe_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] status_o,
    output logic              ryby_pull_low_o
);
    op_mode_e    mode;
    edge_state_t st_d, st_q;
    logic        rd_rise, adv_fast, adv_sect;
    logic        fast_tgl, sect_tgl;

    assign mode = op_mode_e'(op_mode_i);

    always_comb begin
        st_d        = st_q;
        st_d.strobe = rd_strobe_i;
        rd_rise     = rd_strobe_i & ~st_q.strobe;
        adv_fast    = rd_rise & mode_busy(mode);
        adv_sect    = rd_rise & in_sector_i & ((mode == OP_ERASE) || (mode == OP_ESUSP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    stat_toggle_cell u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (op_start_i),
        .adv_i (adv_fast),
        .q_o   (fast_tgl)
    );

    stat_toggle_cell u_sect (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (op_start_i),
        .adv_i (adv_sect),
        .q_o   (sect_tgl)
    );

    stat_word_mux #(.DATA_W(DATA_W)) u_mux (
        .mode_i       (mode),
        .in_sector_i  (in_sector_i),
        .wr_bit7_i    (wr_bit7_i),
        .timeout_i    (timeout_i),
        .buf_abort_i  (buf_abort_i),
        .array_data_i (array_data_i),
        .fast_tgl_i   (fast_tgl),
        .sect_tgl_i   (sect_tgl),
        .status_o     (status_o),
        .pull_low_o   (ryby_pull_low_o)
    );

    // R9: qualified edge flips the fast toggle
    a_r9_fast_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_fast && !op_start_i) |=> (fast_tgl != $past(fast_tgl)));
    // R9: no qualified edge, fast toggle holds
    a_r9_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_fast && !op_start_i) |=> $stable(fast_tgl));
    // R10: reads outside the sector never move the sector toggle
    a_r10_sect_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sector_i && !op_start_i) |=> $stable(sect_tgl));
    // R11: start clears both toggles
    a_r11_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_i |=> (!fast_tgl && !sect_tgl));
    // R4: fast toggle frozen during erase suspend
    a_r4_susp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_ESUSP && !op_start_i) |=> $stable(fast_tgl));
    // R3: fixed erase bits and busy
    a_r3_erase_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_ERASE) |-> (status_o[B_ERS] && !status_o[B_POLL] && ryby_pull_low_o));
    // R7: no timeout, bit 5 low in busy modes
    a_r7_tmo_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy(mode) && !timeout_i) |-> !status_o[B_TMO]);
    // R5: idle reads pass array data, line released
    a_r5_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_IDLE) |-> (status_o == array_data_i && !ryby_pull_low_o));

endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;
    // {mode[3], in_sec, wb7, tmo, abort, array[8], exp_status[8], exp_pull}
    localparam logic [23:0] VEC [NV] = '{
        {3'd1,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1},  // R2
        {3'd1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h80,1'b1},  // R2
        {3'd1,1'b0,1'b0,1'b1,1'b0,8'h00,8'hA0,1'b1},  // R7
        {3'd1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,1'b1},  // R8 abort ignored outside mode 2
        {3'd2,1'b0,1'b1,1'b0,1'b1,8'h00,8'h02,1'b1},  // R8
        {3'd2,1'b0,1'b0,1'b0,1'b0,8'h00,8'h80,1'b1},  // R8
        {3'd2,1'b0,1'b1,1'b1,1'b0,8'h00,8'h20,1'b1},  // R7
        {3'd3,1'b1,1'b1,1'b0,1'b0,8'h00,8'h08,1'b1},  // R3
        {3'd3,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h28,1'b1},  // R3
        {3'd4,1'b1,1'b0,1'b0,1'b0,8'h00,8'h80,1'b0},  // R4
        {3'd4,1'b1,1'b0,1'b1,1'b1,8'hFF,8'h80,1'b0},  // R4
        {3'd4,1'b0,1'b0,1'b1,1'b0,8'h5A,8'h5A,1'b0},  // R5
        {3'd5,1'b0,1'b0,1'b0,1'b0,8'hC3,8'hC3,1'b0},  // R5
        {3'd5,1'b1,1'b0,1'b1,1'b0,8'hC3,8'h00,1'b0},  // R6
        {3'd0,1'b1,1'b0,1'b1,1'b1,8'hA5,8'hA5,1'b0},  // R5 R12
        {3'd6,1'b0,1'b0,1'b0,1'b0,8'h11,8'h80,1'b1},  // R2 R12
        {3'd7,1'b0,1'b0,1'b0,1'b0,8'h3C,8'h3C,1'b0}   // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_mode = 3'd0;
    logic       op_start = 1'b0, in_sector = 1'b0, wr_bit7 = 1'b0;
    logic       timeout = 1'b0, buf_abort = 1'b0, rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] status;
    logic       pull_low;
    int         n_checks = 0, n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_mode_i       (op_mode),
        .op_start_i      (op_start),
        .in_sector_i     (in_sector),
        .wr_bit7_i       (wr_bit7),
        .timeout_i       (timeout),
        .buf_abort_i     (buf_abort),
        .rd_strobe_i     (rd_strobe),
        .array_data_i    (array_data),
        .status_o        (status),
        .ryby_pull_low_o (pull_low)
    );

    task automatic check(string req, logic [7:0] exp_s, logic exp_p);
        n_checks++;
        if (status !== exp_s || pull_low !== exp_p) begin
            n_errors++;
            $display("FAIL %s: status=%h pull=%b expected status=%h pull=%b",
                     req, status, pull_low, exp_s, exp_p);
        end
    endtask

    task automatic set_in(logic [2:0] m, logic sec, logic wb);
        @(negedge clk);
        op_mode = m; in_sector = sec; wr_bit7 = wb;
        timeout = 1'b0; buf_abort = 1'b0;
    endtask

    task automatic read_pulse(int len);
        @(negedge clk);
        rd_strobe = 1'b1;
        for (int i = 0; i < len; i++) @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_in(3'd1, 1'b0, 1'b1);
        #1 check("R1 reset toggles", 8'h00, 1'b1);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {op_mode, in_sector, wr_bit7, timeout, buf_abort, array_data} = VEC[v][23:9];
            #1 check($sformatf("vector %0d", v), VEC[v][8:1], VEC[v][0]);
        end

        // R9: successive reads in program
        set_in(3'd1, 1'b0, 1'b1);
        read_pulse(1); check("R9 first read", 8'h40, 1'b1);
        read_pulse(1); check("R9 second read", 8'h00, 1'b1);
        read_pulse(4); check("R9 long strobe counts once", 8'h40, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 hold without strobe", 8'h40, 1'b1);

        // R11: start clears
        @(negedge clk) op_start = 1'b1;
        @(negedge clk) op_start = 1'b0;
        check("R11 start clears", 8'h00, 1'b1);

        // R10: erase, in and out of sector
        set_in(3'd3, 1'b1, 1'b0);
        read_pulse(1); check("R10 erase in-sector read", 8'h4C, 1'b1);
        set_in(3'd3, 1'b0, 1'b0);
        read_pulse(1); check("R10 erase out-of-sector read", 8'h0C, 1'b1);

        // R4: erase suspend in sector
        set_in(3'd4, 1'b1, 1'b0);
        read_pulse(1); check("R4 suspend read 1", 8'h80, 1'b0);
        read_pulse(1); check("R4 suspend read 2", 8'h84, 1'b0);

        // R10: reads in program suspend leave toggles
        set_in(3'd5, 1'b1, 1'b0);
        read_pulse(1); check("R6 program suspend in sector", 8'h00, 1'b0);
        set_in(3'd4, 1'b1, 1'b0);
        #1 check("R10 no advance in mode 5", 8'h84, 1'b0);

        // R1: reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 mid-run reset", 8'h80, 1'b0);

        // R9: idle reads do not advance
        set_in(3'd0, 1'b0, 1'b0);
        read_pulse(1);
        set_in(3'd1, 1'b0, 1'b1);
        #1 check("R9 idle read ignored", 8'h00, 1'b1);

        // R8: abort with toggling
        @(negedge clk) op_mode = 3'd2; buf_abort = 1'b1;
        read_pulse(1); check("R8 abort with toggle", 8'h42, 1'b1);

        // R11: start beats a strobe edge in the same cycle
        @(negedge clk) rd_strobe = 1'b1; op_start = 1'b1;
        @(negedge clk) rd_strobe = 1'b0; op_start = 1'b0;
        check("R11 clear priority", 8'h02, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule